// File: doc/BRIEF.md
# Control Endpoint Status Register

This block is the control and status register of a USB device's control endpoint. Firmware reaches it over a simple register bus: an address, a write enable, write data and combinational read data. The USB transaction engine reaches it over single-cycle event inputs. The register holds two kinds of bits. Some are request bits that firmware sets, such as the stall request, the final-stage marker and the transmit-packet-loaded bit. Others are status flags that the hardware sets: packet received, stall handshake delivered, and transaction ended early. Two write-only strobe bits retire those flags.

The stall request and the final-stage marker go straight back to the engine as outputs. A one-cycle interrupt pulse is raised in two cases: when a packet arrives, and when hardware retires a loaded transmit packet. Each bit follows its own set and clear rule. When a hardware set and a firmware clear hit the same flag in the same cycle, the hardware set wins.

Top module: `ep0_ctrl_reg`

## Requirements
- R1: After reset every register bit reads 0, and `stall_req`, `data_end_req` and `irq` are 0.
- R2: The register answers only at address 0x11. A read at any other address returns 0x00, and a write at any other address changes nothing.
- R3: Out-ready (bit 0) is set by `ev_rx_pkt`. It is cleared only by writing 1 to the serviced-out strobe (bit 6). Bits 7 and 6 always read 0.
- R4: Setup-end (bit 4) is set by `ev_xfer_end` only while data-end (bit 3) is 0. It is cleared by writing 1 to the serviced-setup strobe (bit 7).
- R5: Writing 1 to bit 5 sets send-stall, which drives `stall_req`. `ev_stall_sent` clears it.
- R6: `ev_stall_sent` sets sent-stall (bit 2). Writing 0 to bit 2 clears it. Writing 1 to bit 2 leaves it unchanged.
- R7: Writing 1 to bit 1 sets in-ready. Any one of `ev_tx_done`, `ev_setup_ovr` or `ev_out_ovr` clears it.
- R8: Writing 1 to bit 3 sets data-end, which drives `data_end_req`. `ev_xfer_end` or `ev_status_done` clears it. Other events leave it set.
- R9: Writes to the read-only bits 4 and 0 have no effect.
- R10: When a hardware set and a firmware clear reach out-ready, setup-end or sent-stall in the same cycle, the flag ends up set.
- R11: `irq` is high for exactly one cycle, in the cycle after either `ev_rx_pkt` or an in-ready clearing event that arrives while in-ready is 1. A clearing event that arrives while in-ready is 0 raises no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register bus address |
| bus_wr | input | 1 | Write enable |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| ev_rx_pkt | input | 1 | Data packet received |
| ev_tx_done | input | 1 | IN packet transmitted |
| ev_setup_ovr | input | 1 | Transmit packet overwritten by a SETUP packet |
| ev_out_ovr | input | 1 | Transmit packet overwritten by an OUT packet |
| ev_stall_sent | input | 1 | Stall handshake transmitted |
| ev_xfer_end | input | 1 | Control transaction ended |
| ev_status_done | input | 1 | Status stage completed |
| stall_req | output | 1 | Stall request to the engine |
| data_end_req | output | 1 | Final-stage marker to the engine |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
Each write and each event is sampled on a rising edge. The flag it touches can be read on `bus_rdata` right after that edge. `irq` comes from its own register, so it is high during the cycle that follows the event's edge and low again one cycle later. The bench drives every stimulus for one cycle starting at a falling edge and samples at the next falling edge. It then checks `irq` once more a cycle later, so each result is read in the cycle in which it is due.

// File: rtl/ep0_pkg.sv
package ep0_pkg;
  localparam int REG_W = 8;

  // bit positions of the endpoint register (fixed by the bus contract)
  localparam int B_SVC_SETUP = 7;
  localparam int B_SVC_OUT   = 6;
  localparam int B_SEND_STL  = 5;
  localparam int B_SETUP_END = 4;
  localparam int B_DATA_END  = 3;
  localparam int B_SENT_STL  = 2;
  localparam int B_IN_RDY    = 1;
  localparam int B_OUT_RDY   = 0;

  typedef struct packed {
    logic svc_setup;
    logic svc_out;
    logic send_stl;
    logic setup_end;
    logic data_end;
    logic sent_stl;
    logic in_rdy;
    logic out_rdy;
  } ep0_word_t;
endpackage

// File: rtl/ep0_rst_sync.sv
module ep0_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/ep0_bus_decode.sv
module ep0_bus_decode #(
  parameter int             ADDR_W   = 8,
  parameter int             DATA_W   = 8,
  parameter logic [7:0]     REG_ADDR = 8'h11
) (
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              addr_hit,
  output logic [DATA_W-1:0] wr_one,
  output logic [DATA_W-1:0] wr_zero
);
  localparam logic [ADDR_W-1:0] MATCH = ADDR_W'(REG_ADDR);

  logic wr_hit;

  always_comb begin
    addr_hit = (bus_addr == MATCH);
    wr_hit   = addr_hit & bus_wr;
    wr_one   = {DATA_W{wr_hit}} &  bus_wdata;
    wr_zero  = {DATA_W{wr_hit}} & ~bus_wdata;
  end
endmodule

// File: rtl/ep0_flag_cell.sv
module ep0_flag_cell #(
  parameter bit SET_WINS = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q_q;
  logic q_d;
  logic upd_en;

  always_comb begin
    upd_en = set_i | clr_i;
    if (set_i && clr_i) q_d = SET_WINS;
    else                q_d = set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q_q <= 1'b0;
    else if (upd_en) q_q <= q_d;
  end

  assign q_o = q_q;
endmodule

// File: rtl/ep0_irq_gen.sv
module ep0_irq_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_evt,
  input  logic in_rdy_q,
  input  logic in_clr_evt,
  output logic irq_o
);
  logic irq_q;
  logic irq_d;

  always_comb begin
    irq_d = rx_evt | (in_rdy_q & in_clr_evt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/ep0_ctrl_reg.sv
module ep0_ctrl_reg #(
  parameter int         ADDR_W   = 8,
  parameter logic [7:0] REG_ADDR = 8'h11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              ev_rx_pkt,
  input  logic              ev_tx_done,
  input  logic              ev_setup_ovr,
  input  logic              ev_out_ovr,
  input  logic              ev_stall_sent,
  input  logic              ev_xfer_end,
  input  logic              ev_status_done,
  output logic              stall_req,
  output logic              data_end_req,
  output logic              irq
);
  import ep0_pkg::*;

  logic             rst_sync_n;
  logic             addr_hit;
  logic [REG_W-1:0] wr_one;
  logic [REG_W-1:0] wr_zero;
  logic             out_rdy_q;
  logic             setup_end_q;
  logic             sent_stl_q;
  logic             send_stl_q;
  logic             data_end_q;
  logic             in_rdy_q;
  logic             in_clr_evt;
  logic             setup_end_set;
  logic             data_end_clr;
  ep0_word_t        word;
  logic             unused_wbits;

  ep0_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  ep0_bus_decode #(.ADDR_W(ADDR_W), .DATA_W(REG_W), .REG_ADDR(REG_ADDR)) u_dec (
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .addr_hit(addr_hit), .wr_one(wr_one), .wr_zero(wr_zero)
  );

  always_comb begin
    in_clr_evt    = ev_tx_done | ev_setup_ovr | ev_out_ovr;
    setup_end_set = ev_xfer_end & ~data_end_q;
    data_end_clr  = ev_xfer_end | ev_status_done;
  end

  // hardware-set flags: set wins over the firmware clear
  ep0_flag_cell #(.SET_WINS(1'b1)) u_out_rdy (
    .clk(clk), .rst_n(rst_sync_n), .set_i(ev_rx_pkt),
    .clr_i(wr_one[B_SVC_OUT]), .q_o(out_rdy_q)
  );
  ep0_flag_cell #(.SET_WINS(1'b1)) u_setup_end (
    .clk(clk), .rst_n(rst_sync_n), .set_i(setup_end_set),
    .clr_i(wr_one[B_SVC_SETUP]), .q_o(setup_end_q)
  );
  ep0_flag_cell #(.SET_WINS(1'b1)) u_sent_stl (
    .clk(clk), .rst_n(rst_sync_n), .set_i(ev_stall_sent),
    .clr_i(wr_zero[B_SENT_STL]), .q_o(sent_stl_q)
  );

  // firmware-set requests: a fresh firmware set outlives a same-cycle clear
  ep0_flag_cell #(.SET_WINS(1'b1)) u_send_stl (
    .clk(clk), .rst_n(rst_sync_n), .set_i(wr_one[B_SEND_STL]),
    .clr_i(ev_stall_sent), .q_o(send_stl_q)
  );
  ep0_flag_cell #(.SET_WINS(1'b1)) u_data_end (
    .clk(clk), .rst_n(rst_sync_n), .set_i(wr_one[B_DATA_END]),
    .clr_i(data_end_clr), .q_o(data_end_q)
  );
  ep0_flag_cell #(.SET_WINS(1'b1)) u_in_rdy (
    .clk(clk), .rst_n(rst_sync_n), .set_i(wr_one[B_IN_RDY]),
    .clr_i(in_clr_evt), .q_o(in_rdy_q)
  );

  ep0_irq_gen u_irq (
    .clk(clk), .rst_n(rst_sync_n), .rx_evt(ev_rx_pkt),
    .in_rdy_q(in_rdy_q), .in_clr_evt(in_clr_evt), .irq_o(irq)
  );

  always_comb begin
    word           = '0;
    word.send_stl  = send_stl_q;
    word.setup_end = setup_end_q;
    word.data_end  = data_end_q;
    word.sent_stl  = sent_stl_q;
    word.in_rdy    = in_rdy_q;
    word.out_rdy   = out_rdy_q;
    bus_rdata      = addr_hit ? word : '0;
  end

  assign stall_req    = send_stl_q;
  assign data_end_req = data_end_q;

  // strobe polarities that no bit acts on
  assign unused_wbits = ^{wr_one[B_SETUP_END], wr_one[B_OUT_RDY], wr_one[B_SENT_STL],
                          wr_zero[7:3], wr_zero[1:0]};
endmodule

// File: rtl/ep0_ctrl_reg_chk.sv
module ep0_ctrl_reg_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] wr_one,
  input logic [7:0] wr_zero,
  input logic       ev_rx_pkt,
  input logic       ev_tx_done,
  input logic       ev_setup_ovr,
  input logic       ev_out_ovr,
  input logic       ev_stall_sent,
  input logic       ev_xfer_end,
  input logic       ev_status_done,
  input logic       out_rdy_q,
  input logic       in_rdy_q,
  input logic       sent_stl_q,
  input logic       stall_req,
  input logic       data_end_req,
  input logic       irq
);
  AST_RX_SETS_OUTRDY: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rx_pkt |=> out_rdy_q); // R3
  AST_OUTRDY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_rdy_q && !wr_one[6]) |=> out_rdy_q); // R3
  AST_STALL_SENT_DROPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_stall_sent && !wr_one[5]) |=> !stall_req); // R5
  AST_SENT_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (sent_stl_q && !wr_zero[2]) |=> sent_stl_q); // R6
  AST_STALL_SENT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stall_sent |=> sent_stl_q); // R10
  AST_INRDY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ((ev_tx_done || ev_setup_ovr || ev_out_ovr) && !wr_one[1]) |=> !in_rdy_q); // R7
  AST_DATAEND_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ((ev_xfer_end || ev_status_done) && !wr_one[3]) |=> !data_end_req); // R8
  AST_IRQ_ON_RX: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rx_pkt |=> irq); // R11
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_rx_pkt && !(in_rdy_q && (ev_tx_done || ev_setup_ovr || ev_out_ovr))) |=> !irq); // R11
endmodule

bind ep0_ctrl_reg ep0_ctrl_reg_chk u_chk (
  .clk(clk), .rst_n(rst_sync_n), .wr_one(wr_one), .wr_zero(wr_zero),
  .ev_rx_pkt(ev_rx_pkt), .ev_tx_done(ev_tx_done), .ev_setup_ovr(ev_setup_ovr),
  .ev_out_ovr(ev_out_ovr), .ev_stall_sent(ev_stall_sent), .ev_xfer_end(ev_xfer_end),
  .ev_status_done(ev_status_done), .out_rdy_q(out_rdy_q), .in_rdy_q(in_rdy_q),
  .sent_stl_q(sent_stl_q), .stall_req(stall_req), .data_end_req(data_end_req),
  .irq(irq)
);

// File: tb/ep0_ctrl_reg_tb.sv
module ep0_ctrl_reg_tb;
  localparam logic [7:0] REG = 8'h11;
  // event mask bits used by step()
  localparam int E_RX = 0, E_TX = 1, E_SOVR = 2, E_OOVR = 3, E_STL = 4, E_END = 5, E_STAT = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] bus_addr = REG;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       ev_rx_pkt = 1'b0, ev_tx_done = 1'b0, ev_setup_ovr = 1'b0, ev_out_ovr = 1'b0;
  logic       ev_stall_sent = 1'b0, ev_xfer_end = 1'b0, ev_status_done = 1'b0;
  logic       stall_req, data_end_req, irq;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  ep0_ctrl_reg u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ev_rx_pkt(ev_rx_pkt),
    .ev_tx_done(ev_tx_done), .ev_setup_ovr(ev_setup_ovr), .ev_out_ovr(ev_out_ovr),
    .ev_stall_sent(ev_stall_sent), .ev_xfer_end(ev_xfer_end),
    .ev_status_done(ev_status_done), .stall_req(stall_req),
    .data_end_req(data_end_req), .irq(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // drive one cycle of bus write and/or events from a falling edge, sample at the next
  task automatic step(input logic wr, input logic [7:0] addr, input logic [7:0] wd,
                      input logic [6:0] ev);
    bus_wr = wr; bus_addr = addr; bus_wdata = wd;
    ev_rx_pkt = ev[E_RX]; ev_tx_done = ev[E_TX]; ev_setup_ovr = ev[E_SOVR];
    ev_out_ovr = ev[E_OOVR]; ev_stall_sent = ev[E_STL]; ev_xfer_end = ev[E_END];
    ev_status_done = ev[E_STAT];
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = REG; bus_wdata = 8'h00;
    {ev_rx_pkt, ev_tx_done, ev_setup_ovr, ev_out_ovr, ev_stall_sent, ev_xfer_end, ev_status_done} = '0;
  endtask

  task automatic wr(input logic [7:0] d);
    step(1'b1, REG, d, 7'd0);
  endtask

  task automatic ev(input logic [6:0] m);
    step(1'b0, REG, 8'h00, m);
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 reg", bus_rdata, 8'h00);
    chk("R1 outputs", {5'd0, stall_req, data_end_req, irq}, 8'h00);
  endtask

  task automatic t_decode();
    step(1'b1, 8'h12, 8'h2A, 7'd0);
    chk("R2 foreign write", bus_rdata, 8'h00);
    wr(8'h02);
    bus_addr = 8'h12; #1;
    chk("R2 foreign read", bus_rdata, 8'h00);
    bus_addr = REG; #1;
    chk("R2 own read", bus_rdata, 8'h02);
    ev(7'b1 << E_TX); idle();
  endtask

  task automatic t_out_ready();
    ev(7'b1 << E_RX);
    chk("R11 rx irq", {7'd0, irq}, 8'h01);
    chk("R3 set", bus_rdata, 8'h01);
    idle();
    chk("R11 one cycle", {7'd0, irq}, 8'h00);
    wr(8'h00);
    chk("R3 write0 keeps", bus_rdata, 8'h01);
    wr(8'h40);
    chk("R3 strobe clears", bus_rdata, 8'h00);
    wr(8'hC0);
    chk("R3 strobes read 0", bus_rdata, 8'h00);
  endtask

  task automatic t_ro_bits();
    wr(8'h11);
    chk("R9 ro write1", bus_rdata, 8'h00);
    ev(7'b1 << E_RX); idle();
    wr(8'h00);
    chk("R9 ro write0", bus_rdata, 8'h01);
    wr(8'h40);
  endtask

  task automatic t_stall();
    wr(8'h20);
    chk("R5 set", bus_rdata, 8'h20);
    chk("R5 stall_req", {7'd0, stall_req}, 8'h01);
    ev(7'b1 << E_STL);
    chk("R5 R6 handshake", bus_rdata, 8'h04);
    chk("R5 stall_req drop", {7'd0, stall_req}, 8'h00);
    wr(8'h04);
    chk("R6 write1 keeps", bus_rdata, 8'h04);
    wr(8'h00);
    chk("R6 write0 clears", bus_rdata, 8'h00);
  endtask

  task automatic t_in_ready();
    for (int k = 0; k < 3; k++) begin
      wr(8'h02);
      chk("R7 set", bus_rdata, 8'h02);
      ev(7'b1 << (E_TX + k));
      chk("R7 hw clear", bus_rdata, 8'h00);
      chk("R11 in irq", {7'd0, irq}, 8'h01);
      idle();
    end
    ev(7'b1 << E_TX);
    chk("R11 no irq idle", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_data_end();
    wr(8'h0A);
    chk("R8 set", bus_rdata, 8'h0A);
    chk("R8 data_end_req", {7'd0, data_end_req}, 8'h01);
    ev(7'b1 << E_TX); idle();
    chk("R8 tx keeps", bus_rdata, 8'h08);
    ev(7'b1 << E_STAT);
    chk("R8 status clears", bus_rdata, 8'h00);
    wr(8'h08);
    ev(7'b1 << E_END);
    chk("R4 R8 end with data-end", bus_rdata, 8'h00);
    chk("R8 data_end_req drop", {7'd0, data_end_req}, 8'h00);
  endtask

  task automatic t_setup_end();
    ev(7'b1 << E_END);
    chk("R4 set", bus_rdata, 8'h10);
    wr(8'h80);
    chk("R4 strobe clears", bus_rdata, 8'h00);
  endtask

  task automatic t_priority();
    step(1'b1, REG, 8'h40, 7'b1 << E_RX); idle();
    chk("R10 out-ready", bus_rdata, 8'h01);
    wr(8'h40);
    ev(7'b1 << E_END);
    step(1'b1, REG, 8'h80, 7'b1 << E_END);
    chk("R10 setup-end", bus_rdata, 8'h10);
    wr(8'h80);
    step(1'b1, REG, 8'h00, 7'b1 << E_STL);
    chk("R10 sent-stall", bus_rdata, 8'h04);
    wr(8'h00);
    chk("R10 cleanup", bus_rdata, 8'h00);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_decode();
    t_out_ready();
    t_ro_bits();
    t_stall();
    t_in_ready();
    t_data_end();
    t_setup_end();
    t_priority();
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule